// File: doc/BRIEF.md
# Cartridge Disk Controller Register File

This block is the bus-facing register set of a controller that serves four cartridge disk drives. A host reaches five 16-bit registers through address bits 3:1: control/status, bus address, disk address, a multipurpose register, and a 6-bit bus address extension. Address bit 0 selects the byte lane when a byte write is made. The block merges byte writes into the current contents. It shows the low two extension bits inside the status word, and it builds the drive-ready and error-summary bits at read time.

A write to the status word with the done bit clear launches a command. The block then issues a one-cycle start pulse together with the function code and the drive number to the command sequencer. A write with the done bit set launches nothing and only adjusts interrupt enable and the interrupt line. The sequencer reports completion with a done pulse and error flags. It can also fill the three-entry multipurpose queue, which the host drains one word per read.

A parameter removes the extension register for the narrow-address bus variant. In that variant any access to that register index returns a bus error.

Top module: `dkc_regfile`

## Requirements
- R1: Register index is bus_addr[3:1]: 0 status, 1 bus address, 2 disk address, 3 multipurpose, 4 extension; indices 5 to 7 read as 0 and writes to them change nothing.
- R2: Status read layout: bit0 ready, bits3:1 function, bits5:4 extension low bits, bit6 interrupt enable, bit7 done, bits9:8 drive, bits14:10 error flags, bit15 error summary; only bits 9:1 are writable (mask 0x03FE).
- R3: Status bit15 reads 1 exactly when any of bits 14:10 is 1.
- R4: Status bit0 reads as the inverse of drv_busy for the drive in bits 9:8.
- R5: A status write with bit7 = 1 starts nothing; if bit6 is 0 it clears irq, and if bit6 is 1 while done was already 1 it raises irq.
- R6: A status write with bit7 = 0 clears done, bits 14:10 and irq, and in the next cycle pulses cmd_start for one cycle with cmd_func = bits3:1 and cmd_drive = bits9:8.
- R7: A seq_done pulse sets done, ORs seq_err[4:0] into status bits 14:10 (seq_err[0] to bit10), and sets irq to the interrupt enable bit.
- R8: A multipurpose read returns entry 0, then entry 1 moves to 0 and entry 2 moves to 1 (entry 2 keeps its value); seq_mp_load fills entry i from seq_mp_words[16*i+15:16*i].
- R9: A bus write to the multipurpose register loads the same (merged) value into all three entries.
- R10: A byte write (bus_byte = 1) with bus_addr[0] = 1 replaces bits 15:8 from bus_wdata[15:8]; with bus_addr[0] = 0 it replaces bits 7:0 from bus_wdata[7:0]; the other byte is kept.
- R11: Bus address bit 0 always reads as 0.
- R12: The extension register holds 6 bits; its bits 1:0 and status bits 5:4 are one storage written from either side; a byte write to the extension at an odd address is ignored.
- R13: With EXT_PRESENT = 0, a read or write of index 4 pulses bus_err in the next cycle, reads 0, and leaves the extension bits unchanged.
- R14: After reset the status reads done = 1 with all other stored bits 0, all other registers and the queue read 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_byte | input | 1 | Byte write when 1, word write when 0 |
| bus_addr | input | 4 | Bits 3:1 register index, bit 0 byte lane |
| bus_wdata | input | 16 | Write data, byte value in its own lane |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | Access to an absent register, cycle after the access |
| drv_busy | input | NUM_DRIVES | Per-drive busy flags |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_err | input | 5 | Error flags merged into status bits 14:10 on seq_done |
| seq_mp_load | input | 1 | Sequencer fill of the multipurpose queue |
| seq_mp_words | input | MP_DEPTH*16 | Queue fill words, entry 0 lowest |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_func | output | 3 | Function code of the current command |
| cmd_drive | output | 2 | Drive number of the current command |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume one bus access per cycle: bus_rd and bus_wr are never high together. They also assume that seq_done, seq_mp_load and a bus write of the same register never fall in one cycle, because the block resolves such collisions by a fixed priority that no property tries to describe. The stimulus issues every access and sequencer pulse in its own cycle, changes drv_busy only between accesses, and feeds both the full variant and the narrow variant with the same bus traffic.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned NUM_IDX  = 1 << IDX_W;
  localparam int unsigned ERR_W    = 5;
  localparam int unsigned EXT_W    = 6;
  localparam logic [WORD_W-1:0] CSR_WMASK = 16'h03FE;

  typedef enum logic [IDX_W-1:0] {
    IDX_CSR = 3'd0,
    IDX_BA  = 3'd1,
    IDX_DA  = 3'd2,
    IDX_MP  = 3'd3,
    IDX_EXT = 3'd4
  } reg_idx_e;

  // Replace one byte lane of cur with the matching lane of wd, or all of it.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] wd,
                                                   input logic is_byte,
                                                   input logic hi_lane);
    if (!is_byte)      return wd;
    else if (hi_lane)  return {wd[15:8], cur[7:0]};
    else               return {cur[15:8], wd[7:0]};
  endfunction

  // Build the status word as the host sees it.
  function automatic logic [WORD_W-1:0] csr_compose(input logic [ERR_W-1:0] err,
                                                    input logic [1:0] drv,
                                                    input logic done,
                                                    input logic ie,
                                                    input logic [1:0] mirror,
                                                    input logic [2:0] fn,
                                                    input logic rdy);
    return {|err, err, drv, done, ie, mirror, fn, rdy};
  endfunction

endpackage

// File: rtl/dkc_bus_decode.sv
module dkc_bus_decode #(
  parameter bit EXT_PRESENT = 1'b1
) (
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  output logic [dkc_pkg::NUM_IDX-1:0] rd_hit,
  output logic [dkc_pkg::NUM_IDX-1:0] wr_hit,
  output logic       nx_hit
);
  import dkc_pkg::*;

  logic [IDX_W-1:0] idx;
  assign idx = bus_addr[3:1];

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_hit
    if (i == int'(IDX_EXT) && !EXT_PRESENT) begin : g_absent
      assign rd_hit[i] = 1'b0;
      assign wr_hit[i] = 1'b0;
    end else begin : g_present
      assign rd_hit[i] = bus_rd && (idx == IDX_W'(i));
      assign wr_hit[i] = bus_wr && (idx == IDX_W'(i));
    end
  end

  if (EXT_PRESENT) begin : g_nx_none
    assign nx_hit = 1'b0;
  end else begin : g_nx_ext
    assign nx_hit = (bus_rd || bus_wr) && (idx == IDX_EXT);
  end

endmodule

// File: rtl/dkc_csr.sv
module dkc_csr #(
  parameter int unsigned NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [9:1]            wfield,
  input  logic                  seq_done,
  input  logic [dkc_pkg::ERR_W-1:0] seq_err,
  input  logic [NUM_DRIVES-1:0] drv_busy,
  input  logic [1:0]            ext_lo,
  output logic [15:0]           csr_val,
  output logic                  cmd_start,
  output logic [2:0]            cmd_func,
  output logic [1:0]            cmd_drive,
  output logic                  irq
);
  import dkc_pkg::*;

  logic [2:0]       func_q;
  logic [1:0]       drv_q;
  logic             ie_q;
  logic             done_q;
  logic [ERR_W-1:0] err_q;
  logic             irq_q;
  logic             start_q;

  // Named events of a status write.
  logic wr_launch;
  logic wr_ctrl_only;
  logic irq_raise_evt;
  logic irq_drop_evt;
  logic drive_ready;

  assign wr_launch     = wr && !wfield[7];
  assign wr_ctrl_only  = wr &&  wfield[7];
  assign irq_raise_evt = wr_ctrl_only &&  wfield[6] && done_q;
  assign irq_drop_evt  = wr_ctrl_only && !wfield[6];

  assign drive_ready = !drv_busy[drv_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q  <= '0;
      drv_q   <= '0;
      ie_q    <= 1'b0;
      done_q  <= 1'b1;
      err_q   <= '0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr) begin
        func_q <= wfield[3:1];
        ie_q   <= wfield[6];
        drv_q  <= wfield[9:8];
        done_q <= wfield[7];
        if (wr_launch) begin
          err_q   <= '0;
          irq_q   <= 1'b0;
          start_q <= 1'b1;
        end else if (irq_drop_evt) begin
          irq_q <= 1'b0;
        end else if (irq_raise_evt) begin
          irq_q <= 1'b1;
        end
      end else if (seq_done) begin
        done_q <= 1'b1;
        err_q  <= err_q | seq_err;
        irq_q  <= ie_q;
      end
    end
  end

  assign csr_val   = csr_compose(err_q, drv_q, done_q, ie_q, ext_lo, func_q, drive_ready);
  assign cmd_start = start_q;
  assign cmd_func  = func_q;
  assign cmd_drive = drv_q;
  assign irq       = irq_q;

  // R6
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !done_q && (err_q == '0) && !irq_q);

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ie_q);

  // R5
  ctrl_write_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_only |=> !cmd_start);

  // R7
  seq_done_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !wr) |=> done_q && (irq_q == $past(ie_q)));

endmodule

// File: rtl/dkc_mp_queue.sv
module dkc_mp_queue #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_all,
  input  logic [W-1:0]       load_val,
  input  logic               seq_load,
  input  logic [DEPTH*W-1:0] seq_words,
  input  logic               pop,
  output logic [W-1:0]       head
);
  logic [W-1:0] q [DEPTH];

  logic ripple_evt;
  assign ripple_evt = pop && !load_all && !seq_load;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (load_all) begin
        q[i] <= load_val;
      end else if (seq_load) begin
        q[i] <= seq_words[i*W +: W];
      end else if (pop && (i < DEPTH-1)) begin
        q[i] <= q[(i < DEPTH-1) ? i+1 : i];
      end
    end

    if (i > 0) begin : g_chk
      // R9
      load_all_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_all |=> (q[i] == q[0]));
      // R8
      ripple_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ripple_evt |=> (q[i-1] == $past(q[i])));
    end
  end

  assign head = q[0];

  // R8
  last_entry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ripple_evt |=> $stable(q[DEPTH-1]));

endmodule

// File: rtl/dkc_addr_regs.sv
module dkc_addr_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ba_wr,
  input  logic        da_wr,
  input  logic        ext_wr,
  input  logic        ext_odd_byte,
  input  logic        csr_wr,
  input  logic [15:0] wval,
  output logic [15:0] ba_val,
  output logic [15:0] da_val,
  output logic [dkc_pkg::EXT_W-1:0] ext_val
);
  import dkc_pkg::*;

  logic [15:1]      ba_q;
  logic [15:0]      da_q;
  logic [EXT_W-1:0] ext_q;
  logic             ext_take;

  assign ext_take = ext_wr && !ext_odd_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ba_q  <= '0;
      da_q  <= '0;
      ext_q <= '0;
    end else begin
      if (ba_wr) ba_q <= wval[15:1];
      if (da_wr) da_q <= wval;
      if (ext_take)     ext_q      <= wval[EXT_W-1:0];
      else if (csr_wr)  ext_q[1:0] <= wval[5:4];
    end
  end

  assign ba_val  = {ba_q, 1'b0};
  assign da_val  = da_q;
  assign ext_val = ext_q;

  // R12
  ext_odd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr && ext_odd_byte && !csr_wr) |=> $stable(ext_q));

endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile #(
  parameter int unsigned NUM_DRIVES  = 4,
  parameter int unsigned MP_DEPTH    = 3,
  parameter bit          EXT_PRESENT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic                     bus_byte,
  input  logic [3:0]               bus_addr,
  input  logic [15:0]              bus_wdata,
  output logic [15:0]              bus_rdata,
  output logic                     bus_err,
  input  logic [NUM_DRIVES-1:0]    drv_busy,
  input  logic                     seq_done,
  input  logic [4:0]               seq_err,
  input  logic                     seq_mp_load,
  input  logic [MP_DEPTH*16-1:0]   seq_mp_words,
  output logic                     cmd_start,
  output logic [2:0]               cmd_func,
  output logic [1:0]               cmd_drive,
  output logic                     irq
);
  import dkc_pkg::*;

  logic [NUM_IDX-1:0] rd_hit;
  logic [NUM_IDX-1:0] wr_hit;
  logic               nx_hit;

  logic [15:0]      csr_val;
  logic [15:0]      ba_val;
  logic [15:0]      da_val;
  logic [15:0]      mp_head;
  logic [EXT_W-1:0] ext_val;

  logic [15:0] cur_val;
  logic [15:0] merged;
  logic [15:0] rd_val;

  logic [15:0] rdata_q;
  logic        err_q;
  logic        rd_csr_q;
  logic        rd_ba_q;

  dkc_bus_decode #(.EXT_PRESENT(EXT_PRESENT)) u_dec (
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .nx_hit   (nx_hit)
  );

  // Current value of the addressed register, for byte merging.
  always_comb begin
    unique case (bus_addr[3:1])
      IDX_CSR: cur_val = csr_val;
      IDX_BA:  cur_val = ba_val;
      IDX_DA:  cur_val = da_val;
      IDX_MP:  cur_val = mp_head;
      IDX_EXT: cur_val = {{(16-EXT_W){1'b0}}, ext_val};
      default: cur_val = '0;
    endcase
  end

  assign merged = lane_merge(cur_val, bus_wdata, bus_byte, bus_addr[0]);

  dkc_csr #(.NUM_DRIVES(NUM_DRIVES)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_hit[IDX_CSR]),
    .wfield    (merged[9:1]),
    .seq_done  (seq_done),
    .seq_err   (seq_err),
    .drv_busy  (drv_busy),
    .ext_lo    (ext_val[1:0]),
    .csr_val   (csr_val),
    .cmd_start (cmd_start),
    .cmd_func  (cmd_func),
    .cmd_drive (cmd_drive),
    .irq       (irq)
  );

  dkc_addr_regs u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .ba_wr        (wr_hit[IDX_BA]),
    .da_wr        (wr_hit[IDX_DA]),
    .ext_wr       (wr_hit[IDX_EXT]),
    .ext_odd_byte (bus_byte && bus_addr[0]),
    .csr_wr       (wr_hit[IDX_CSR]),
    .wval         (merged),
    .ba_val       (ba_val),
    .da_val       (da_val),
    .ext_val      (ext_val)
  );

  dkc_mp_queue #(.DEPTH(MP_DEPTH), .W(16)) u_mpq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_all  (wr_hit[IDX_MP]),
    .load_val  (merged),
    .seq_load  (seq_mp_load),
    .seq_words (seq_mp_words),
    .pop       (rd_hit[IDX_MP]),
    .head      (mp_head)
  );

  // One-hot read mux; unused and absent indices read 0.
  always_comb begin
    rd_val = '0;
    if (rd_hit[IDX_CSR]) rd_val = rd_val | (csr_val & ~CSR_WMASK) | (csr_val & CSR_WMASK);
    if (rd_hit[IDX_BA])  rd_val = rd_val | ba_val;
    if (rd_hit[IDX_DA])  rd_val = rd_val | da_val;
    if (rd_hit[IDX_MP])  rd_val = rd_val | mp_head;
    if (rd_hit[IDX_EXT]) rd_val = rd_val | {{(16-EXT_W){1'b0}}, ext_val};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      err_q    <= 1'b0;
      rd_csr_q <= 1'b0;
      rd_ba_q  <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_val;
      err_q    <= nx_hit;
      rd_csr_q <= rd_hit[IDX_CSR];
      rd_ba_q  <= rd_hit[IDX_BA];
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R3
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_csr_q |-> (bus_rdata[15] == (|bus_rdata[14:10])));

  // R11
  ba_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ba_q |-> !bus_rdata[0]);

  // R6
  start_from_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(wr_hit[IDX_CSR]) && !$past(merged[7]));

  // R13
  absent_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(bus_rd)) |-> (bus_rdata == '0));

endmodule

// File: tb/dkc_regfile_tb.sv
`timescale 1ns/1ps
module dkc_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [3:0]  drv_busy = '0;
  logic        seq_done = 1'b0;
  logic [4:0]  seq_err = '0;
  logic        seq_mp_load = 1'b0;
  logic [47:0] seq_mp_words = '0;

  logic [15:0] bus_rdata, rdata_nx;
  logic        bus_err, err_nx;
  logic        cmd_start, start_nx;
  logic [2:0]  cmd_func, func_nx;
  logic [1:0]  cmd_drive, drive_nx;
  logic        irq, irq_nx;

  int checks = 0;
  int fails  = 0;
  int starts = 0;
  bit done_flag = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        mon_pend = 1'b0;

  always #4 clk = ~clk;

  dkc_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .drv_busy(drv_busy), .seq_done(seq_done), .seq_err(seq_err), .seq_mp_load(seq_mp_load),
    .seq_mp_words(seq_mp_words), .cmd_start(cmd_start), .cmd_func(cmd_func),
    .cmd_drive(cmd_drive), .irq(irq)
  );

  dkc_regfile #(.EXT_PRESENT(1'b0)) u_dut_nx (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_nx), .bus_err(err_nx),
    .drv_busy(drv_busy), .seq_done(seq_done), .seq_err(seq_err), .seq_mp_load(seq_mp_load),
    .seq_mp_words(seq_mp_words), .cmd_start(start_nx), .cmd_func(func_nx),
    .cmd_drive(drive_nx), .irq(irq_nx)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one-cycle write.
  task automatic do_wr(input logic [2:0] idx, input logic [15:0] d, input bit byt, input bit hi);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {idx, hi}; bus_wdata = d; bus_byte = byt;
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  // Driver: one-cycle read with an expected value pushed to the scoreboard.
  task automatic do_rd(input logic [2:0] idx, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {idx, 1'b0};
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic seq_pulse(input logic [4:0] e);
    @(negedge clk);
    seq_done = 1'b1; seq_err = e;
    @(negedge clk);
    seq_done = 1'b0; seq_err = '0;
  endtask

  // Monitor: compares the registered read data one cycle after each read.
  always @(posedge clk) mon_pend <= bus_rd;
  always @(negedge clk) begin
    if (mon_pend && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata == e, t, bus_rdata, e);
    end
  end

  always @(negedge clk) if (rst_n && cmd_start) starts++;

  initial begin
    #(8 * 100000);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R14 reset state
    do_rd(3'd0, 16'h0081, "R14 status after reset");
    do_rd(3'd1, 16'h0000, "R14 bus address after reset");
    do_rd(3'd2, 16'h0000, "R14 disk address after reset");
    do_rd(3'd3, 16'h0000, "R14 queue after reset");
    do_rd(3'd4, 16'h0000, "R14 extension after reset");
    chk(irq == 1'b0, "R14 irq after reset", {15'd0, irq}, 16'h0);

    // R11 bus address bit 0
    do_wr(3'd1, 16'h1235, 1'b0, 1'b0);
    do_rd(3'd1, 16'h1234, "R11 bus address bit0 reads 0");

    // R10 byte lanes on the disk address
    do_wr(3'd2, 16'hABCD, 1'b0, 1'b0);
    do_wr(3'd2, 16'h12FF, 1'b1, 1'b1);
    do_rd(3'd2, 16'h12CD, "R10 high byte write");
    do_wr(3'd2, 16'hFF34, 1'b1, 1'b0);
    do_rd(3'd2, 16'h1234, "R10 low byte write");

    // R1 unused indices
    do_wr(3'd6, 16'hFFFF, 1'b0, 1'b0);
    do_rd(3'd5, 16'h0000, "R1 index 5 reads 0");
    do_rd(3'd2, 16'h1234, "R1 write to index 6 leaves disk address");
    do_rd(3'd1, 16'h1234, "R1 write to index 6 leaves bus address");

    // R9 queue bus write
    do_wr(3'd3, 16'h0100, 1'b0, 1'b0);
    do_rd(3'd3, 16'h0100, "R9 queue entry 0");
    do_rd(3'd3, 16'h0100, "R9 queue entry 1");
    do_rd(3'd3, 16'h0100, "R9 queue entry 2");
    do_wr(3'd3, 16'hAB00, 1'b1, 1'b1);
    do_rd(3'd3, 16'hAB00, "R9 R10 queue byte write");

    // R8 queue ripple
    @(negedge clk);
    seq_mp_load = 1'b1; seq_mp_words = {16'h3333, 16'h2222, 16'h1111};
    @(negedge clk);
    seq_mp_load = 1'b0;
    do_rd(3'd3, 16'h1111, "R8 first pop");
    do_rd(3'd3, 16'h2222, "R8 second pop");
    do_rd(3'd3, 16'h3333, "R8 third pop");
    do_rd(3'd3, 16'h3333, "R8 last entry kept");

    // R5 control-only writes
    do_wr(3'd0, 16'h00C0, 1'b0, 1'b0);
    chk(irq == 1'b1, "R5 enable with done raises irq", {15'd0, irq}, 16'h1);
    do_wr(3'd0, 16'h0080, 1'b0, 1'b0);
    chk(irq == 1'b0, "R5 disable clears irq", {15'd0, irq}, 16'h0);
    chk(starts == 0, "R5 no start on done writes", 16'(starts), 16'h0);

    // R12 extension mirror, R13 absent variant
    do_wr(3'd4, 16'h003F, 1'b0, 1'b0);
    chk(err_nx == 1'b1, "R13 write to absent extension errs", {15'd0, err_nx}, 16'h1);
    do_rd(3'd4, 16'h003F, "R12 extension holds 6 bits");
    chk(err_nx == 1'b1 && rdata_nx == 16'h0, "R13 read of absent extension", rdata_nx, 16'h0);
    chk(bus_err == 1'b0, "R13 present variant no error", {15'd0, bus_err}, 16'h0);
    do_rd(3'd0, 16'h00B1, "R12 extension bits in status");
    chk(rdata_nx == 16'h0081, "R13 absent variant mirror unchanged", rdata_nx, 16'h0081);
    do_wr(3'd0, 16'h0090, 1'b0, 1'b0);
    do_rd(3'd4, 16'h003D, "R12 status write reaches extension");
    do_wr(3'd4, 16'hFF00, 1'b1, 1'b1);
    do_rd(3'd4, 16'h003D, "R12 odd byte write to extension ignored");

    // R6 launch, R4 ready
    drv_busy = 4'b0100;
    do_wr(3'd0, 16'h024C, 1'b0, 1'b0);
    chk(cmd_start == 1'b1, "R6 start pulse", {15'd0, cmd_start}, 16'h1);
    chk(cmd_func == 3'd6 && cmd_drive == 2'd2, "R6 function and drive",
        {11'd0, cmd_drive, cmd_func}, {11'd0, 2'd2, 3'd6});
    @(negedge clk);
    chk(cmd_start == 1'b0, "R6 start lasts one cycle", {15'd0, cmd_start}, 16'h0);
    do_rd(3'd0, 16'h024C, "R4 R2 busy drive not ready");

    // R7 completion, R3 summary
    drv_busy = 4'b0000;
    seq_pulse(5'b00100);
    chk(irq == 1'b1, "R7 completion raises irq", {15'd0, irq}, 16'h1);
    do_rd(3'd0, 16'h92CD, "R7 R3 done and error flags");

    // R2 write mask, R6 error clear
    do_wr(3'd0, 16'hFC47, 1'b0, 1'b0);
    chk(irq == 1'b0, "R6 launch clears irq", {15'd0, irq}, 16'h0);
    do_rd(3'd0, 16'h0047, "R2 R6 only bits 9:1 written, errors cleared");
    do_rd(3'd4, 16'h003C, "R12 extension after status write");
    chk(starts == 2, "R6 two launches counted", 16'(starts), 16'h2);

    repeat (2) @(negedge clk);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule